// File: doc/BRIEF.md
# Per-Cycle Reconfigurable 8-bit Datapath

This block is an 8-bit processing element. On every clock edge it runs the operation that one row of an internal configuration table describes. A 3-bit configuration address picks the row, and that address may change from one cycle to the next. Each row sets five things: the arithmetic or logic function, which accumulator feeds the first operand, which register feeds the second operand, a shift stage placed after the function, and an output mask. The row also says which accumulators, if any, take the masked result. Two 8-bit accumulators hold running values. Two 8-bit data registers hold constants.

Every cycle the block also compares two fixed register pairs, each under its own mask. It detects a zero result, an all-ones result, and carry or borrow. All of this lands on a registered 8-bit flag bus, with a registered copy of the result beside it. A host port writes the configuration rows and the four working registers and reads any of them back. A sleep input clears the accumulators and leaves the data registers untouched.

Top module: `dyncfg_datapath`

## Requirements
- R1: While `rst_n` is low at a clock edge, every configuration row, both accumulators, both data registers, `flag_bus` and `result` become zero.
- R2: A host write (`host_we`=1) at address 0..7 loads configuration row `host_addr`, and addresses 8, 9, 10 and 11 load A0, A1, D0 and D1 from `host_wdata[7:0]`. `host_rdata` combinationally returns the addressed item, with registers zero-extended. The row layout is: function in bits [2:0], first-operand select in bit [3] (0=A0, 1=A1), second-operand select in bits [5:4] (0=D0, 1=D1, 2=A0, 3=A1), shift in bits [7:6], destination in bits [9:8], mask in bits [17:10].
- R3: The function code selects: 0 pass the first operand, 1 increment, 2 decrement, 3 add, 4 subtract (first minus second), 5 AND, 6 OR, 7 XOR.
- R4: Destination code 0 writes no accumulator, 1 writes A0, 2 writes A1, and 3 writes both. An accumulator that is not selected keeps its value.
- R5: The shift code selects: 0 no shift. 1 left shift, with `shift_in` entering bit 0 and the old bit 7 becoming shift-out. 2 right shift, with `shift_in` entering bit 7 and the old bit 0 becoming shift-out. 3 nibble swap. Shift-out is 0 for codes 0 and 3.
- R6: The shifted value is ANDed with the row mask before it is written back or flagged.
- R7: `flag_bus[0]` is set when the masked result is 0x00, and `flag_bus[1]` is set when it is 0xFF.
- R8: `flag_bus[2]` is the carry out of increment or add, or the borrow of decrement or subtract. It is 0 for the other functions. `flag_bus[3]` is the shift-out bit.
- R9: Comparator 0 compares A0 with D0 under mask `CMP0_MASK`, and comparator 1 compares A1 with D1 under `CMP1_MASK`. Each uses the register values from before that edge. Equal goes to `flag_bus[4]` and `flag_bus[6]`; unsigned less-than goes to `flag_bus[5]` and `flag_bus[7]`.
- R10: `flag_bus` and `result` are registered. They show the operation of a cycle only after the clock edge that ends that cycle.
- R11: While `sleep` is high, both accumulators are cleared at each edge, and neither datapath write-back nor host writes change them. Data registers keep their values.
- R12: When a host write and a datapath write-back target the same accumulator in one cycle, the host value wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep | input | 1 | Clears and holds the accumulators |
| cfg_addr | input | 3 | Configuration row run this cycle |
| shift_in | input | 1 | Serial bit for left and right shifts |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Host address: rows 0..7, registers 8..11 |
| host_wdata | input | 18 | Host write data |
| host_rdata | output | 18 | Host read data for `host_addr` |
| result | output | 8 | Registered masked result |
| flag_bus | output | 8 | Registered flags {lt1, eq1, lt0, eq0, shift-out, carry, ones, zero} |

## Verification
On every cycle, assertions check four things: the mask never lets a cleared bit through, and the logic functions never raise carry. The zero and all-ones flags are never set together, and a comparator never reports equal and less-than at once. They also check that a sleeping accumulator is cleared while the data registers hold, that an accumulator not selected as destination stays put, and that the host wins a write collision. The actual arithmetic of each function, the shift-in and shift-out bits, the operand routing and the one-cycle flag latency are shown only by the bench's vector table and directed scenarios. Those scenarios compare results and readbacks against values worked out by hand.

// File: rtl/dp_pkg.sv
// Shared types for the reconfigurable datapath.
// Assumes an 8-bit data width throughout; the row layout is fixed here.
package dp_pkg;
    localparam int DW = 8;

    typedef enum logic [2:0] {
        FN_PASS, FN_INC, FN_DEC, FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR
    } alu_fn_e;

    typedef enum logic [1:0] {
        SH_NONE, SH_LEFT, SH_RIGHT, SH_SWAP
    } shift_e;

    typedef enum logic [1:0] {
        WB_NONE, WB_A0, WB_A1, WB_BOTH
    } wb_e;

    typedef enum logic [1:0] {
        BS_D0, BS_D1, BS_A0, BS_A1
    } bsrc_e;

    typedef struct packed {
        logic [DW-1:0] mask;
        wb_e           wb;
        shift_e        sh;
        bsrc_e         bsrc;
        logic          asrc;
        alu_fn_e       fn;
    } cfg_row_t;
endpackage

// File: rtl/dp_cfg_mem.sv
// Configuration table: DEPTH rows of cfg_row_t.
// One row is selected by the execute address each cycle.
// A second read port serves host readback, and one synchronous write port loads rows.
// Assumes the caller qualifies the write enable with the address range.
module dp_cfg_mem
    import dp_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AW-1:0]  waddr,
    input  cfg_row_t       wdata,
    input  logic [AW-1:0]  exec_addr,
    output cfg_row_t       exec_row,
    input  logic [AW-1:0]  host_raddr,
    output cfg_row_t       host_row
);
    cfg_row_t rows [DEPTH];

    // Clear all rows on reset, otherwise take host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) rows[i] <= '0;
        end else if (we) begin
            rows[waddr] <= wdata;
        end
    end

    assign exec_row = rows[exec_addr];
    assign host_row = rows[host_raddr];
endmodule

// File: rtl/dp_alu.sv
// Function unit, shift stage and output mask for one datapath cycle.
// Purely combinational; the clock and reset feed only the assertions.
// Carry means carry out for inc/add and borrow for dec/sub.
module dp_alu
    import dp_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  cfg_row_t       row,
    input  logic [DW-1:0]  opa,
    input  logic [DW-1:0]  opb,
    input  logic           shift_in,
    output logic [DW-1:0]  res,
    output logic           carry,
    output logic           shift_out
);
    logic [DW:0]   wide;
    logic [DW-1:0] shifted;

    // Compute the function result, with one extra bit for carry or borrow.
    always_comb begin
        unique case (row.fn)
            FN_PASS: wide = {1'b0, opa};
            FN_INC:  wide = {1'b0, opa} + 1'b1;
            FN_DEC:  wide = {1'b0, opa} - 1'b1;
            FN_ADD:  wide = {1'b0, opa} + {1'b0, opb};
            FN_SUB:  wide = {1'b0, opa} - {1'b0, opb};
            FN_AND:  wide = {1'b0, opa & opb};
            FN_OR:   wide = {1'b0, opa | opb};
            FN_XOR:  wide = {1'b0, opa ^ opb};
            default: wide = '0;
        endcase
    end

    assign carry = (row.fn inside {FN_INC, FN_DEC, FN_ADD, FN_SUB}) ? wide[DW] : 1'b0;

    // Apply the selected shift, with the serial bit entering and leaving.
    always_comb begin
        unique case (row.sh)
            SH_LEFT:  begin shifted = {wide[DW-2:0], shift_in};       shift_out = wide[DW-1]; end
            SH_RIGHT: begin shifted = {shift_in, wide[DW-1:1]};       shift_out = wide[0];    end
            SH_SWAP:  begin shifted = {wide[DW/2-1:0], wide[DW-1:DW/2]}; shift_out = 1'b0;    end
            default:  begin shifted = wide[DW-1:0];                   shift_out = 1'b0;       end
        endcase
    end

    assign res = shifted & row.mask;

    AST_MASK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (res & ~row.mask) == '0);                                  // R6
    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (row.fn inside {FN_PASS, FN_AND, FN_OR, FN_XOR}) |-> !carry); // R8
endmodule

// File: rtl/dp_cmp.sv
// Masked comparator: equal and unsigned less-than of two operands.
// The mask is fixed by a parameter.
module dp_cmp
    import dp_pkg::*;
#(
    parameter logic [DW-1:0] MASK = '1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DW-1:0]  x,
    input  logic [DW-1:0]  y,
    output logic           eq,
    output logic           lt
);
    logic [DW-1:0] xm, ym;

    assign xm = x & MASK;
    assign ym = y & MASK;
    assign eq = (xm == ym);
    assign lt = (xm < ym);

    AST_CMP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(eq && lt));                                              // R9
endmodule

// File: rtl/dyncfg_datapath.sv
// Top: accumulators, data registers, host port, configuration table,
// function unit, two comparators and the registered flag and result outputs.
// Assumes CFG_DEPTH is a power of two.
// Registers sit at host addresses CFG_DEPTH..CFG_DEPTH+3.
module dyncfg_datapath
    import dp_pkg::*;
#(
    parameter int            CFG_DEPTH = 8,
    parameter logic [DW-1:0] CMP0_MASK = 8'hFF,
    parameter logic [DW-1:0] CMP1_MASK = 8'hF0,
    localparam int CFG_AW = $clog2(CFG_DEPTH),
    localparam int HA_W   = CFG_AW + 1,
    localparam int CFG_W  = $bits(cfg_row_t)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic              shift_in,
    input  logic              host_we,
    input  logic [HA_W-1:0]   host_addr,
    input  logic [CFG_W-1:0]  host_wdata,
    output logic [CFG_W-1:0]  host_rdata,
    output logic [DW-1:0]     result,
    output logic [DW-1:0]     flag_bus
);
    localparam logic [HA_W-1:0] REG_A0 = HA_W'(CFG_DEPTH);
    localparam logic [HA_W-1:0] REG_A1 = HA_W'(CFG_DEPTH + 1);
    localparam logic [HA_W-1:0] REG_D0 = HA_W'(CFG_DEPTH + 2);
    localparam logic [HA_W-1:0] REG_D1 = HA_W'(CFG_DEPTH + 3);
    localparam int NCMP = 2;
    localparam logic [NCMP-1:0][DW-1:0] CMP_MASKS = {CMP1_MASK, CMP0_MASK};

    logic [DW-1:0] a0_q, a1_q, d0_q, d1_q;
    cfg_row_t      row, host_row;
    logic [DW-1:0] opa, opb, alu_res;
    logic          carry, shout;
    logic          cfg_we, wr_a0, wr_a1, wr_d0, wr_d1;
    logic [NCMP-1:0][DW-1:0] cmp_x, cmp_y;
    logic [NCMP-1:0] cmp_eq, cmp_lt;

    // Decode host writes into row and register strobes.
    assign cfg_we = host_we && (host_addr < REG_A0);
    assign wr_a0  = host_we && (host_addr == REG_A0);
    assign wr_a1  = host_we && (host_addr == REG_A1);
    assign wr_d0  = host_we && (host_addr == REG_D0);
    assign wr_d1  = host_we && (host_addr == REG_D1);

    dp_cfg_mem #(.DEPTH(CFG_DEPTH)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .we(cfg_we), .waddr(host_addr[CFG_AW-1:0]), .wdata(cfg_row_t'(host_wdata)),
        .exec_addr(cfg_addr), .exec_row(row),
        .host_raddr(host_addr[CFG_AW-1:0]), .host_row(host_row)
    );

    // Route the operands that the current row selects.
    always_comb begin
        opa = row.asrc ? a1_q : a0_q;
        unique case (row.bsrc)
            BS_D0:   opb = d0_q;
            BS_D1:   opb = d1_q;
            BS_A0:   opb = a0_q;
            default: opb = a1_q;
        endcase
    end

    dp_alu u_alu (
        .clk(clk), .rst_n(rst_n), .row(row), .opa(opa), .opb(opb),
        .shift_in(shift_in), .res(alu_res), .carry(carry), .shift_out(shout)
    );

    assign cmp_x = {a1_q, a0_q};
    assign cmp_y = {d1_q, d0_q};

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        dp_cmp #(.MASK(CMP_MASKS[g])) u_cmp (
            .clk(clk), .rst_n(rst_n), .x(cmp_x[g]), .y(cmp_y[g]),
            .eq(cmp_eq[g]), .lt(cmp_lt[g])
        );
    end

    // Accumulator A0: reset, sleep clear, host write, then write-back.
    always_ff @(posedge clk) begin
        if (!rst_n || sleep) a0_q <= '0;
        else if (wr_a0)      a0_q <= host_wdata[DW-1:0];
        else if (row.wb[0])  a0_q <= alu_res;
    end

    // Accumulator A1: same priority as A0.
    always_ff @(posedge clk) begin
        if (!rst_n || sleep) a1_q <= '0;
        else if (wr_a1)      a1_q <= host_wdata[DW-1:0];
        else if (row.wb[1])  a1_q <= alu_res;
    end

    // Data registers: host writes only, unaffected by sleep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d0_q <= '0;
            d1_q <= '0;
        end else begin
            if (wr_d0) d0_q <= host_wdata[DW-1:0];
            if (wr_d1) d1_q <= host_wdata[DW-1:0];
        end
    end

    // Register the flag bus and result one cycle behind the operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_bus <= '0;
            result   <= '0;
        end else begin
            flag_bus <= {cmp_lt[1], cmp_eq[1], cmp_lt[0], cmp_eq[0],
                         shout, carry, (alu_res == '1), (alu_res == '0)};
            result   <= alu_res;
        end
    end

    // Host readback multiplexer.
    always_comb begin
        unique case (host_addr)
            REG_A0:  host_rdata = CFG_W'(a0_q);
            REG_A1:  host_rdata = CFG_W'(a1_q);
            REG_D0:  host_rdata = CFG_W'(d0_q);
            REG_D1:  host_rdata = CFG_W'(d1_q);
            default: host_rdata = (host_addr < REG_A0) ? CFG_W'(host_row) : '0;
        endcase
    end

    AST_SLEEP_CLEARS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (a0_q == '0 && a1_q == '0));                     // R11
    AST_SLEEP_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !host_we) |=> ($stable(d0_q) && $stable(d1_q))); // R11
    AST_NO_DEST_HOLDS_A0: assert property (@(posedge clk) disable iff (!rst_n)
        (!row.wb[0] && !wr_a0 && !sleep) |=> $stable(a0_q));       // R4
    AST_HOST_WINS_A0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a0 && !sleep) |=> (a0_q == $past(host_wdata[DW-1:0])));  // R12
    AST_ZERO_ONES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_bus[0] && flag_bus[1]));                            // R7
endmodule

// File: tb/sim_dyncfg_datapath.sv
`timescale 1ns/1ps
module sim_dyncfg_datapath;
    localparam real HALF = 4.0;   // 125 MHz

    typedef struct packed {
        logic [7:0] a0, a1;
        logic [2:0] row;
        logic       sin;
        logic [7:0] res;
        logic [3:0] fl;     // {shift-out, carry, ones, zero}
        logic [7:0] na0, na1;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{8'hF5, 8'h00, 3'd0, 1'b0, 8'h04, 4'b0100, 8'h04, 8'h00},  // add carry
        '{8'h10, 8'h00, 3'd1, 1'b0, 8'hBB, 4'b0100, 8'h10, 8'hBB},  // sub borrow
        '{8'h00, 8'h7F, 3'd2, 1'b1, 8'h01, 4'b1000, 8'h00, 8'h01},  // inc, left
        '{8'h00, 8'h00, 3'd3, 1'b1, 8'hFF, 4'b1110, 8'hFF, 8'h00},  // dec, right
        '{8'h3C, 8'hC3, 3'd4, 1'b0, 8'hFF, 4'b0010, 8'hFF, 8'hFF},  // xor swap both
        '{8'h00, 8'hFF, 3'd5, 1'b0, 8'h05, 4'b0000, 8'h00, 8'hFF},  // and masked
        '{8'h12, 8'hAB, 3'd6, 1'b0, 8'hA0, 4'b0000, 8'hA0, 8'hAB},  // pass A1 masked
        '{8'h00, 8'h00, 3'd7, 1'b0, 8'h0F, 4'b0000, 8'h00, 8'h00},  // or no dest
        '{8'hF1, 8'h00, 3'd0, 1'b0, 8'h00, 4'b0101, 8'h00, 8'h00},  // add to zero
        '{8'h00, 8'hFF, 3'd2, 1'b0, 8'h00, 4'b0101, 8'h00, 8'h00}   // inc wrap
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep = 1'b0;
    logic [2:0]  cfg_addr = 3'd7;
    logic        shift_in = 1'b0;
    logic        host_we = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [17:0] host_wdata = '0;
    logic [17:0] host_rdata;
    logic [7:0]  result, flag_bus;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(HALF) clk = ~clk;

    dyncfg_datapath u0 (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .cfg_addr(cfg_addr),
        .shift_in(shift_in), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .result(result), .flag_bus(flag_bus)
    );

    function automatic logic [17:0] mkrow(input logic [2:0] fn, input logic as,
        input logic [1:0] bs, input logic [1:0] sh, input logic [1:0] wb, input logic [7:0] m);
        return {m, wb, sh, bs, as, fn};
    endfunction

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [3:0] a, input logic [17:0] d);
        @(negedge clk);
        cfg_addr = 3'd7; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #2;
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [17:0] d);
        host_addr = a; #1; d = host_rdata;
    endtask

    task automatic step(input logic [2:0] r, input logic s);
        @(negedge clk);
        cfg_addr = r; shift_in = s;
        @(posedge clk); #2;
        cfg_addr = 3'd7;
    endtask

    initial begin
        logic [17:0] rv;
        logic [17:0] rows [8];
        rows[0] = mkrow(3'd3, 1'b0, 2'd0, 2'd0, 2'd1, 8'hFF);
        rows[1] = mkrow(3'd4, 1'b0, 2'd1, 2'd0, 2'd2, 8'hFF);
        rows[2] = mkrow(3'd1, 1'b1, 2'd0, 2'd1, 2'd2, 8'hFF);
        rows[3] = mkrow(3'd2, 1'b0, 2'd0, 2'd2, 2'd1, 8'hFF);
        rows[4] = mkrow(3'd7, 1'b0, 2'd3, 2'd3, 2'd3, 8'hFF);
        rows[5] = mkrow(3'd5, 1'b1, 2'd1, 2'd0, 2'd0, 8'h0F);
        rows[6] = mkrow(3'd0, 1'b1, 2'd0, 2'd0, 2'd1, 8'hF0);
        rows[7] = mkrow(3'd6, 1'b0, 2'd0, 2'd0, 2'd0, 8'hFF);

        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        check("R1 result", 18'(result), 18'h0);
        check("R1 flags", 18'(flag_bus), 18'h0);
        for (int i = 8; i < 12; i++) begin
            rd(4'(i), rv); check("R1 register", rv, 18'h0);
        end
        rd(4'd3, rv); check("R1 row", rv, 18'h0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < 8; i++) hwrite(4'(i), rows[i]);
        hwrite(4'd10, 18'h0F);
        hwrite(4'd11, 18'h55);
        // R2: readback of a row and a data register
        rd(4'd4, rv); check("R2 row readback", rv, rows[4]);
        rd(4'd11, rv); check("R2 D1 readback", rv, 18'h55);

        // Vector table: R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            hwrite(4'd8, 18'(VEC[v].a0));
            hwrite(4'd9, 18'(VEC[v].a1));
            step(VEC[v].row, VEC[v].sin);
            check("R3/R6 result", 18'(result), 18'(VEC[v].res));
            check("R5/R7/R8 flags", 18'(flag_bus[3:0]), 18'(VEC[v].fl));
            rd(4'd8, rv); check("R4 A0 after", rv, 18'(VEC[v].na0));
            rd(4'd9, rv); check("R4 A1 after", rv, 18'(VEC[v].na1));
        end

        // R9: comparators, equal / less / greater
        hwrite(4'd8, 18'h0F); hwrite(4'd9, 18'h5A);
        step(3'd7, 1'b0);
        check("R9 cmp equal", 18'(flag_bus[7:4]), 18'b0101);
        hwrite(4'd8, 18'h03); hwrite(4'd9, 18'h40);
        step(3'd7, 1'b0);
        check("R9 cmp less", 18'(flag_bus[7:4]), 18'b1010);
        hwrite(4'd8, 18'hFF); hwrite(4'd9, 18'h60);
        step(3'd7, 1'b0);
        check("R9 cmp greater", 18'(flag_bus[7:4]), 18'b0000);

        // R10: flag shows only after the edge
        hwrite(4'd8, 18'hF1);
        @(negedge clk); cfg_addr = 3'd0; #1;
        check("R10 before edge", 18'(flag_bus[0]), 18'h0);
        @(posedge clk); #2; cfg_addr = 3'd7;
        check("R10 after edge", 18'(flag_bus[0]), 18'h1);

        // R11: sleep clears accumulators, keeps data, ignores host
        hwrite(4'd8, 18'hAA); hwrite(4'd9, 18'h55);
        @(negedge clk); sleep = 1'b1;
        step(3'd0, 1'b0);
        hwrite(4'd8, 18'h77);
        rd(4'd8, rv); check("R11 A0 cleared", rv, 18'h0);
        rd(4'd9, rv); check("R11 A1 cleared", rv, 18'h0);
        rd(4'd10, rv); check("R11 D0 kept", rv, 18'h0F);
        rd(4'd11, rv); check("R11 D1 kept", rv, 18'h55);
        @(negedge clk); sleep = 1'b0;

        // R12: host write beats write-back to A0
        hwrite(4'd8, 18'h10);
        @(negedge clk);
        cfg_addr = 3'd0; host_we = 1'b1; host_addr = 4'd8; host_wdata = 18'h77;
        @(posedge clk); #2; host_we = 1'b0; cfg_addr = 3'd7;
        rd(4'd8, rv); check("R12 host wins", rv, 18'h77);

        // R1: reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #2;
        rd(4'd8, rv); check("R1 A0 after reset", rv, 18'h0);
        rd(4'd10, rv); check("R1 D0 after reset", rv, 18'h0);
        @(negedge clk); rst_n = 1'b1;

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule